// File: doc/BRIEF.md
# Subtract and Bitwise Execute Stage

This block is one execute slot for a 32-bit processor with 16-bit instruction words. Each cycle it may be handed an instruction word along with three operand values already read from the register file: the register named by the n field, the register named by the m field, and register zero. It also receives the current value of the single-bit condition flag. It decodes the word and computes the outcome of the three subtract flavours and the bitwise group (AND, OR, XOR, complement, and the flag-only test). Immediate variants apply an 8-bit constant to register zero.

One clock after issue it presents the result, a write request with the destination register index, and the next value of the condition flag. Every opcode outside the handled set raises an illegal flag instead of writing. The register file, the storage for the flag and all memory-operand variants sit outside the block. Data width, immediate width and the style of the subtractor are parameters.

Top module: `sublog_exec`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_vld`, `wr_en`, `illegal` and `t_out` are all 0.
- R2: Outputs for an instruction issued with `iss_vld`=1 appear in the following cycle with `res_vld`=1. A cycle with `iss_vld`=0 gives `res_vld`=0, `wr_en`=0 and `illegal`=0 one cycle later.
- R3: `0011nnnnmmmm1000` writes Rn−Rm to register n. `t_out` equals `t_in`.
- R4: `0011nnnnmmmm1010` writes Rn−Rm−T to register n. `t_out` is the borrow out of that unsigned 32-bit subtraction.
- R5: `0011nnnnmmmm1011` writes Rn−Rm to register n. `t_out` is 1 exactly when the signed difference falls outside the signed 32-bit range.
- R6: The register forms with prefix `0010` and low nibble `1001` (AND), `1011` (OR) and `1010` (XOR) write Rn op Rm to register n. `t_out` equals `t_in`.
- R7: The immediate forms `11001001iiiiiiii` (AND), `11001011iiiiiiii` (OR) and `11001010iiiiiiii` (XOR) write R0 op zero-extended immediate to register 0. `t_out` equals `t_in`.
- R8: `0110nnnnmmmm0111` writes the bitwise complement of Rm to register n. `t_out` equals `t_in`.
- R9: The test forms `0010nnnnmmmm1000` (Rn AND Rm) and `11001000iiiiiiii` (R0 AND zero-extended immediate) set `t_out` to 1 when the AND is zero and to 0 otherwise. They give `wr_en`=0.
- R10: Any other instruction word gives `illegal`=1 and `wr_en`=0, and `t_out` equals `t_in`.
- R11: `wr_en` and `illegal` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | An instruction is issued this cycle |
| insn | input | 16 | Instruction word |
| rn_val | input | 32 | Value of register selected by bits 11:8 |
| rm_val | input | 32 | Value of register selected by bits 7:4 |
| r0_val | input | 32 | Value of register 0 |
| t_in | input | 1 | Current condition flag |
| res_vld | output | 1 | Outputs belong to an issued instruction |
| res_data | output | 32 | Computed result |
| wr_en | output | 1 | Write res_data to the register file |
| wr_idx | output | 4 | Destination register index |
| t_out | output | 1 | Next condition flag |
| illegal | output | 1 | Issued word is not a handled opcode |

## Verification
Subtract-with-borrow and subtract-with-underflow each deliver a register write and a flag update in the same output cycle. Both must come from the same operands and must not disturb each other. The bench provokes this with operands placed exactly on the borrow and signed-range boundaries (zero minus zero with the flag set, the most negative value minus one, the most positive value minus minus one). It also feeds a long random stream of mixed encodings and raw words. For each output cycle it judges the written value, the destination index and the new flag together against a bench model that uses 64-bit signed arithmetic.

// File: rtl/sublog_pkg.sv
package sublog_pkg;
   typedef enum logic [3:0] {
      OP_ILL, OP_SUB, OP_SUBC, OP_SUBV,
      OP_AND, OP_OR, OP_XOR, OP_TST, OP_NOT
   } op_e;

   typedef struct packed {
      op_e  op;
      logic imm_form;
   } dec_t;
endpackage

// File: rtl/sublog_dec.sv
module sublog_dec
   import sublog_pkg::*;
(
   input  logic [15:0] insn,
   output dec_t        dec
);
   logic [3:0] hi, nfield, lo;
   assign hi     = insn[15:12];
   assign nfield = insn[11:8];
   assign lo     = insn[3:0];

   always_comb begin
      dec.op       = OP_ILL;
      dec.imm_form = 1'b0;
      unique case (hi)
         4'h3: case (lo)
            4'h8: dec.op = OP_SUB;
            4'hA: dec.op = OP_SUBC;
            4'hB: dec.op = OP_SUBV;
            default: dec.op = OP_ILL;
         endcase
         4'h2: case (lo)
            4'h8: dec.op = OP_TST;
            4'h9: dec.op = OP_AND;
            4'hA: dec.op = OP_XOR;
            4'hB: dec.op = OP_OR;
            default: dec.op = OP_ILL;
         endcase
         4'h6: dec.op = (lo == 4'h7) ? OP_NOT : OP_ILL;
         4'hC: begin
            dec.imm_form = 1'b1;
            case (nfield)
               4'h8: dec.op = OP_TST;
               4'h9: dec.op = OP_AND;
               4'hA: dec.op = OP_XOR;
               4'hB: dec.op = OP_OR;
               default: begin
                  dec.op       = OP_ILL;
                  dec.imm_form = 1'b0;
               end
            endcase
         end
         default: dec.op = OP_ILL;
      endcase
   end
endmodule

// File: rtl/sublog_sub.sv
module sublog_sub #(
   parameter int DATA_W    = 32,
   parameter int SUB_STYLE = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              bin,
   output logic [DATA_W-1:0] diff,
   output logic              bout,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   generate
      if (SUB_STYLE == 0) begin : g_direct
         logic [DATA_W:0] wide;
         assign wide = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bin};
         assign diff = wide[MSB:0];
         assign bout = wide[DATA_W];
      end else begin : g_invadd
         logic [DATA_W:0] sum;
         assign sum  = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, ~bin};
         assign diff = sum[MSB:0];
         assign bout = ~sum[DATA_W];
      end
   endgenerate

   assign ovf = (a[MSB] ^ b[MSB]) & (diff[MSB] ^ a[MSB]);
endmodule

// File: rtl/sublog_logic.sv
module sublog_logic
   import sublog_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              is_zero
);
   always_comb begin
      unique case (op)
         OP_AND, OP_TST: res = a & b;
         OP_OR:          res = a | b;
         OP_XOR:         res = a ^ b;
         OP_NOT:         res = ~b;
         default:        res = '0;
      endcase
   end
   assign is_zero = (res == '0);
endmodule

// File: rtl/sublog_exec.sv
module sublog_exec
   import sublog_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 4,
   parameter int IMM_W     = 8,
   parameter int SUB_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_vld,
   input  logic [15:0]       insn,
   input  logic [DATA_W-1:0] rn_val,
   input  logic [DATA_W-1:0] rm_val,
   input  logic [DATA_W-1:0] r0_val,
   input  logic              t_in,
   output logic              res_vld,
   output logic [DATA_W-1:0] res_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              t_out,
   output logic              illegal
);
   localparam int PAD_W = DATA_W - IMM_W;

   generate
      if (DATA_W <= IMM_W) begin : g_bad_width
         $error("DATA_W must exceed IMM_W");
      end
      if (IDX_W != 4) begin : g_bad_idx
         $error("IDX_W must match the 4-bit register fields");
      end
      if (SUB_STYLE != 0 && SUB_STYLE != 1) begin : g_bad_style
         $error("SUB_STYLE must be 0 or 1");
      end
   endgenerate

   dec_t dec;
   sublog_dec u_dec (.insn(insn), .dec(dec));

   logic [DATA_W-1:0] imm_ext, opa, opb;
   assign imm_ext = {{PAD_W{1'b0}}, insn[IMM_W-1:0]};
   assign opa     = dec.imm_form ? r0_val  : rn_val;
   assign opb     = dec.imm_form ? imm_ext : rm_val;

   logic [DATA_W-1:0] s_diff;
   logic              s_bout, s_ovf;
   sublog_sub #(.DATA_W(DATA_W), .SUB_STYLE(SUB_STYLE)) u_sub (
      .a(opa), .b(opb), .bin((dec.op == OP_SUBC) & t_in),
      .diff(s_diff), .bout(s_bout), .ovf(s_ovf)
   );

   logic [DATA_W-1:0] l_res;
   logic              l_zero;
   sublog_logic #(.DATA_W(DATA_W)) u_log (
      .op(dec.op), .a(opa), .b(opb), .res(l_res), .is_zero(l_zero)
   );

   logic [DATA_W-1:0] nx_res;
   logic              nx_wr, nx_t, nx_ill;
   logic [IDX_W-1:0]  nx_idx;

   always_comb begin
      nx_res = l_res;
      nx_t   = t_in;
      nx_wr  = 1'b1;
      nx_ill = 1'b0;
      nx_idx = dec.imm_form ? '0 : insn[11:8];
      unique case (dec.op)
         OP_SUB:  nx_res = s_diff;
         OP_SUBC: begin nx_res = s_diff; nx_t = s_bout; end
         OP_SUBV: begin nx_res = s_diff; nx_t = s_ovf;  end
         OP_TST:  begin nx_wr = 1'b0; nx_t = l_zero; end
         OP_ILL:  begin nx_wr = 1'b0; nx_ill = 1'b1; nx_res = '0; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_data <= '0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         t_out    <= 1'b0;
         illegal  <= 1'b0;
      end else begin
         res_vld  <= iss_vld;
         res_data <= nx_res;
         wr_en    <= iss_vld & nx_wr;
         wr_idx   <= nx_idx;
         t_out    <= nx_t;
         illegal  <= iss_vld & nx_ill;
      end
   end

   logic is_tst_w, is_not_w, is_sub_w;
   assign is_tst_w = (insn[15:12] == 4'h2 && insn[3:0] == 4'h8) || insn[15:8] == 8'hC8;
   assign is_not_w = (insn[15:12] == 4'h6 && insn[3:0] == 4'h7);
   assign is_sub_w = (insn[15:12] == 4'h3 && insn[3:0] == 4'h8);

   // R11
   excl_wr_ill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && illegal));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_vld |=> (!res_vld && !wr_en && !illegal));

   // R9
   tst_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && is_tst_w) |=> !wr_en);

   // R8
   not_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && is_not_w) |=> (res_data == ~$past(rm_val) && wr_en));

   // R3
   sub_keeps_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_vld && is_sub_w) |=> (t_out == $past(t_in)));

   // R10
   ill_keeps_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (t_out == $past(t_in) && !wr_en));
endmodule

// File: tb/sim_sublog_exec.sv
module sim_sublog_exec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_vld = 1'b0;
   logic [15:0] insn = '0;
   logic [31:0] rn_val = '0, rm_val = '0, r0_val = '0;
   logic        t_in = 1'b0;
   logic        res_vld, wr_en, t_out, illegal;
   logic [31:0] res_data;
   logic [3:0]  wr_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   sublog_exec u0 (
      .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .insn(insn),
      .rn_val(rn_val), .rm_val(rm_val), .r0_val(r0_val), .t_in(t_in),
      .res_vld(res_vld), .res_data(res_data), .wr_en(wr_en),
      .wr_idx(wr_idx), .t_out(t_out), .illegal(illegal)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [15:0] i, input logic [31:0] rn, rm, r0,
                        input logic t, output logic ill, wr,
                        output logic [3:0] idx, output logic [31:0] res,
                        output logic tn, output string req);
      longint sa, sb, sd;
      logic [32:0] w;
      logic [31:0] imm;
      imm = {24'd0, i[7:0]};
      ill = 0; wr = 1; idx = i[11:8]; res = 0; tn = t; req = "R10";
      if (i[15:12] == 4'h3 && i[3:0] == 4'h8) begin
         res = rn - rm; req = "R3";
      end else if (i[15:12] == 4'h3 && i[3:0] == 4'hA) begin
         w = {1'b0, rn} - {1'b0, rm} - {32'd0, t};
         res = w[31:0]; tn = w[32]; req = "R4";
      end else if (i[15:12] == 4'h3 && i[3:0] == 4'hB) begin
         sa = longint'($signed(rn)); sb = longint'($signed(rm)); sd = sa - sb;
         res = rn - rm; tn = (sd > 64'sd2147483647) || (sd < -64'sd2147483648); req = "R5";
      end else if (i[15:12] == 4'h2 && i[3:0] == 4'h9) begin
         res = rn & rm; req = "R6";
      end else if (i[15:12] == 4'h2 && i[3:0] == 4'hB) begin
         res = rn | rm; req = "R6";
      end else if (i[15:12] == 4'h2 && i[3:0] == 4'hA) begin
         res = rn ^ rm; req = "R6";
      end else if (i[15:12] == 4'h2 && i[3:0] == 4'h8) begin
         wr = 0; tn = ((rn & rm) == 0); req = "R9";
      end else if (i[15:8] == 8'hC9) begin
         res = r0 & imm; idx = 0; req = "R7";
      end else if (i[15:8] == 8'hCB) begin
         res = r0 | imm; idx = 0; req = "R7";
      end else if (i[15:8] == 8'hCA) begin
         res = r0 ^ imm; idx = 0; req = "R7";
      end else if (i[15:8] == 8'hC8) begin
         wr = 0; tn = ((r0 & imm) == 0); req = "R9";
      end else if (i[15:12] == 4'h6 && i[3:0] == 4'h7) begin
         res = ~rm; req = "R8";
      end else begin
         ill = 1; wr = 0;
      end
   endtask

   task automatic issue(input logic [15:0] i, input logic [31:0] rn, rm, r0,
                        input logic t);
      logic ill, wr, tn;
      logic [3:0] idx;
      logic [31:0] res;
      string req;
      @(negedge clk);
      iss_vld = 1; insn = i; rn_val = rn; rm_val = rm; r0_val = r0; t_in = t;
      model(i, rn, rm, r0, t, ill, wr, idx, res, tn, req);
      @(posedge clk); #2;
      chk("R2", "res_vld", {31'd0, res_vld}, 32'd1);
      chk(req, "illegal", {31'd0, illegal}, {31'd0, ill});
      chk(req, "wr_en", {31'd0, wr_en}, {31'd0, wr});
      chk(req, "t_out", {31'd0, t_out}, {31'd0, tn});
      chk("R11", "wr_en&illegal", {31'd0, wr_en & illegal}, 32'd0);
      if (wr) begin
         chk(req, "wr_idx", {28'd0, wr_idx}, {28'd0, idx});
         chk(req, "res_data", res_data, res);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      iss_vld = 0; insn = 16'h3008;
      @(posedge clk); #2;
      chk("R2", "idle res_vld", {31'd0, res_vld}, 32'd0);
      chk("R2", "idle wr_en", {31'd0, wr_en}, 32'd0);
      chk("R2", "idle illegal", {31'd0, illegal}, 32'd0);
   endtask

   function automatic logic [15:0] pick_insn();
      logic [15:0] w;
      w = 16'($urandom);
      case ($urandom % 14)
         0: return {4'h3, w[11:4], 4'h8};
         1: return {4'h3, w[11:4], 4'hA};
         2: return {4'h3, w[11:4], 4'hB};
         3: return {4'h2, w[11:4], 4'h9};
         4: return {4'h2, w[11:4], 4'hA};
         5: return {4'h2, w[11:4], 4'hB};
         6: return {4'h2, w[11:4], 4'h8};
         7: return {4'h6, w[11:4], 4'h7};
         8: return {8'hC9, w[7:0]};
         9: return {8'hCA, w[7:0]};
         10: return {8'hCB, w[7:0]};
         11: return {8'hC8, w[7:0]};
         default: return w;
      endcase
   endfunction

   function automatic logic [31:0] pick_val();
      case ($urandom % 6)
         0: return 32'h0;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'h7FFF_FFFF;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #2;
      // R1: outputs cleared under reset
      chk("R1", "res_vld", {31'd0, res_vld}, 32'd0);
      chk("R1", "wr_en", {31'd0, wr_en}, 32'd0);
      chk("R1", "illegal", {31'd0, illegal}, 32'd0);
      chk("R1", "t_out", {31'd0, t_out}, 32'd0);
      @(negedge clk); rst_n = 1;
      @(posedge clk); #2;
      chk("R1", "post-reset res_vld", {31'd0, res_vld}, 32'd0);

      issue(16'h3458, 32'd5, 32'd3, 32'd0, 1'b1);                  // R3
      issue(16'h312A, 32'd0, 32'd0, 32'd0, 1'b1);                  // R4 borrow
      issue(16'h312A, 32'd5, 32'd5, 32'd0, 1'b0);                  // R4 no borrow
      issue(16'h312A, 32'd5, 32'd4, 32'd0, 1'b1);                  // R4 exact zero
      issue(16'h3A1B, 32'h8000_0000, 32'd1, 32'd0, 1'b0);          // R5 low edge
      issue(16'h3A1B, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b0);  // R5 high edge
      issue(16'h3A1B, 32'd5, 32'd3, 32'd0, 1'b1);                  // R5 no underflow
      issue(16'h2349, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'd0, 1'b1);  // R6
      issue(16'h234B, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'd0, 1'b0);  // R6
      issue(16'h234A, 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'd0, 1'b1);  // R6
      issue(16'hC9FF, 32'h1, 32'h2, 32'hFFFF_FF00, 1'b1);          // R7 zero-extend
      issue(16'hCB80, 32'h1, 32'h2, 32'hFFFF_FF00, 1'b0);          // R7
      issue(16'hCA0F, 32'h1, 32'h2, 32'h1234_5678, 1'b0);          // R7
      issue(16'h6E57, 32'h0, 32'hA5A5_0000, 32'd0, 1'b0);          // R8
      issue(16'hC80F, 32'h0, 32'h0, 32'hFFFF_FFF0, 1'b0);          // R9 zero
      issue(16'hC80F, 32'h0, 32'h0, 32'h0000_0001, 1'b1);          // R9 nonzero
      issue(16'h2128, 32'hFF00, 32'h00FF, 32'd0, 1'b0);            // R9 reg
      issue(16'h0000, 32'h1, 32'h1, 32'd1, 1'b1);                  // R10
      issue(16'hFFFF, 32'h1, 32'h1, 32'd1, 1'b0);                  // R10
      issue(16'hCC12, 32'h1, 32'h1, 32'd1, 1'b1);                  // R10 memory form
      idle();                                                       // R2

      for (int k = 0; k < 600; k++) begin
         if (($urandom % 10) == 0) idle();
         else issue(pick_insn(), pick_val(), pick_val(), pick_val(), 1'($urandom));
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule